// File: doc/BRIEF.md
# Sliding-Window Rank Order Filter

The block tracks the most recent `DEPTH` accepted samples (64 by default, each `DATA_W` = 12 bits) as one list, kept sorted from largest to smallest. For every new sample it reports the entry at a selectable rank. Setting the rank to the top of the list gives a running maximum. Setting it to the bottom gives a running minimum. The middle position gives a running median.

The list is never rebuilt from scratch. Each accepted sample takes one macrocycle of two clock cycles. In the first cycle the sample that has just left the window is removed, and every entry below it moves up one place. In the second cycle the new sample is placed into position, and every entry ranked below it moves down one place. Each position compares its own stored value against the broadcast key in a single cycle. The sample to remove comes from an internal delay line of `DEPTH` entries, which is a memory addressed by a wrapping pointer. Until the window has filled, unused positions hold an empty marker that ranks below any real sample.

Top module: `rank_window_filter`

## Requirements
- R1: The window is exactly the last `DEPTH` accepted samples. Every value from 0 to 2^`DATA_W`-1 is a valid sample, and 0 is distinct from an empty position.
- R2: `rank_sel` = r selects the (r+1)-th largest value in the window. r = 0 gives the maximum, r = `DEPTH`-1 the minimum, and r = `DEPTH`/2-1 the upper median. `rank_sel` is sampled in the second cycle of the macrocycle.
- R3: A sample is accepted when `in_valid` is high in a cycle that does not directly follow an accepting cycle. An `in_valid` pulse in the cycle right after an acceptance is ignored, together with its data.
- R4: `out_valid` is a single-cycle pulse. It appears exactly two cycles after the accepting cycle, and `out_sample` carries the ranked result that includes the new sample.
- R5: `out_valid` stays low for the first `DEPTH`-1 accepted samples. The first pulse belongs to the `DEPTH`-th sample.
- R6: When the window holds equal values, removing an expired sample removes exactly one copy.
- R7: A sample drops out of the window exactly when the (`DEPTH`+1)-th later sample is accepted, counting from itself.
- R8: `out_sample` holds its value between `out_valid` pulses.
- R9: After reset, `out_valid` and `out_sample` are 0 and the window is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Offers a new sample |
| in_sample | input | DATA_W | Sample value |
| rank_sel | input | $clog2(DEPTH) | Zero-based rank from the largest |
| out_valid | output | 1 | Result pulse |
| out_sample | output | DATA_W | Value at the selected rank |

## Verification
The bench runs a window of 8 entries with 4-bit samples, so repeated values are frequent. It sweeps every rank against a sorted model of the recent history. Tie handling is stressed with runs of equal values: a delete that removed every matching copy, or none, would shift each rank by one and give wrong outputs. Pulses arriving in the busy second cycle carry extreme values; a design that accepted them would let those values reach the maximum or minimum rank. A long run of the top value followed by smaller values shows whether expiry happens one sample too early or too late. The fill phase shows whether `out_valid` rises before the window is full.

// File: rtl/rwf_pkg.sv
package rwf_pkg;
   // Operation broadcast to every tap for one clock cycle
   typedef enum logic [1:0] {
      TAP_HOLD = 2'd0,
      TAP_DEL  = 2'd1,
      TAP_INS  = 2'd2
   } tap_op_e;

   // Half of a macrocycle the control sits in
   typedef enum logic {
      PH_IDLE = 1'b0,
      PH_INS  = 1'b1
   } phase_e;
endpackage

// File: rtl/rwf_delay_line.sv
module rwf_delay_line #(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int  PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit  POW2  = ((1 << PTR_W) == DEPTH);

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [PTR_W-1:0]  ptr_q;
   logic [PTR_W-1:0]  ptr_nxt;

   generate
      if (POW2) begin : g_wrap_free
         assign ptr_nxt = ptr_q + 1'b1;
      end else begin : g_wrap_cmp
         assign ptr_nxt = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
      end
   endgenerate

   // The slot about to be overwritten holds the sample DEPTH pushes old
   assign dout = mem_q[ptr_q];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ptr_q <= '0;
      else if (push) ptr_q <= ptr_nxt;
   end

   always_ff @(posedge clk) begin
      if (push) mem_q[ptr_q] <= din;
   end
endmodule

// File: rtl/rwf_tap.sv
module rwf_tap
   import rwf_pkg::*;
#(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tap_op_e           op,
   input  logic [DATA_W-1:0] key,
   input  logic              up_live,
   input  logic [DATA_W-1:0] up_val,
   input  logic              up_flag,
   input  logic              dn_live,
   input  logic [DATA_W-1:0] dn_val,
   output logic              live_o,
   output logic [DATA_W-1:0] val_o,
   output logic              flag_o,
   output logic              nxt_live_o,
   output logic [DATA_W-1:0] nxt_val_o
);
   logic              live_q;
   logic [DATA_W-1:0] val_q;
   logic              flag;
   logic              nxt_live;
   logic [DATA_W-1:0] nxt_val;

   // Comparator: on delete, flag marks the matching entry and all below it;
   // on insert, flag marks every entry ranked below the new key.
   always_comb begin
      unique case (op)
         TAP_DEL: flag = !(live_q && (val_q > key));
         TAP_INS: flag = !live_q || (val_q < key);
         default: flag = 1'b0;
      endcase
   end

   always_comb begin
      nxt_live = live_q;
      nxt_val  = val_q;
      if (flag) begin
         if (op == TAP_DEL) begin
            nxt_live = dn_live;
            nxt_val  = dn_val;
         end else if (op == TAP_INS) begin
            if (up_flag) begin
               nxt_live = up_live;
               nxt_val  = up_val;
            end else begin
               nxt_live = 1'b1;
               nxt_val  = key;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live_q <= 1'b0;
         val_q  <= '0;
      end else begin
         live_q <= nxt_live;
         val_q  <= nxt_val;
      end
   end

   assign live_o     = live_q;
   assign val_o      = val_q;
   assign flag_o     = flag;
   assign nxt_live_o = nxt_live;
   assign nxt_val_o  = nxt_val;
endmodule

// File: rtl/rwf_rank_pick.sv
module rwf_rank_pick #(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 64,
   parameter int SEL_W  = 6
) (
   input  logic [DEPTH*DATA_W-1:0] vals_flat,
   input  logic [SEL_W-1:0]        sel,
   output logic [DATA_W-1:0]       pick
);
   localparam bit POW2 = ((1 << SEL_W) == DEPTH);

   generate
      if (POW2) begin : g_direct
         assign pick = vals_flat[sel*DATA_W +: DATA_W];
      end else begin : g_clamped
         logic [SEL_W-1:0] sel_c;
         assign sel_c = (sel > SEL_W'(DEPTH - 1)) ? SEL_W'(DEPTH - 1) : sel;
         assign pick  = vals_flat[sel_c*DATA_W +: DATA_W];
      end
   endgenerate
endmodule

// File: rtl/rank_window_filter.sv
module rank_window_filter
   import rwf_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [DATA_W-1:0]          in_sample,
   input  logic [$clog2(DEPTH)-1:0]   rank_sel,
   output logic                       out_valid,
   output logic [DATA_W-1:0]          out_sample
);
   localparam int RANK_W = $clog2(DEPTH);
   localparam int CNT_W  = $clog2(DEPTH + 1);

   initial begin
      assert (DEPTH >= 2) else $error("DEPTH must be at least 2");
      assert (DATA_W >= 1) else $error("DATA_W must be at least 1");
   end

   phase_e             phase_q;
   logic [DATA_W-1:0]  hold_q;
   logic [CNT_W-1:0]   fill_q;
   logic               out_valid_q;
   logic [DATA_W-1:0]  out_q;

   logic               accept;
   logic               full;
   tap_op_e            tap_op;
   logic [DATA_W-1:0]  tap_key;
   logic [DATA_W-1:0]  old_sample;
   logic [DATA_W-1:0]  picked;

   logic               live_a [DEPTH];
   logic [DATA_W-1:0]  val_a  [DEPTH];
   logic               flag_a [DEPTH];
   logic [DEPTH-1:0]   live_vec;
   logic [DEPTH*DATA_W-1:0] val_flat;
   logic [DEPTH*DATA_W-1:0] nxt_flat;

   assign accept = in_valid && (phase_q == PH_IDLE);
   assign full   = (fill_q == CNT_W'(DEPTH));

   always_comb begin
      tap_op  = TAP_HOLD;
      tap_key = old_sample;
      if (phase_q == PH_INS) begin
         tap_op  = TAP_INS;
         tap_key = hold_q;
      end else if (accept && full) begin
         tap_op  = TAP_DEL;
      end
   end

   rwf_delay_line #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (accept),
      .din   (in_sample),
      .dout  (old_sample)
   );

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_tap
         logic              u_live;
         logic [DATA_W-1:0] u_val;
         logic              u_flag;
         logic              d_live;
         logic [DATA_W-1:0] d_val;
         logic              n_live;

         if (i == 0) begin : g_head
            assign u_live = 1'b0;
            assign u_val  = '0;
            assign u_flag = 1'b0;
         end else begin : g_link_up
            assign u_live = live_a[i-1];
            assign u_val  = val_a[i-1];
            assign u_flag = flag_a[i-1];
         end

         if (i == DEPTH - 1) begin : g_tail
            assign d_live = 1'b0;
            assign d_val  = '0;
         end else begin : g_link_dn
            assign d_live = live_a[i+1];
            assign d_val  = val_a[i+1];
         end

         rwf_tap #(.DATA_W(DATA_W)) u_tap (
            .clk        (clk),
            .rst_n      (rst_n),
            .op         (tap_op),
            .key        (tap_key),
            .up_live    (u_live),
            .up_val     (u_val),
            .up_flag    (u_flag),
            .dn_live    (d_live),
            .dn_val     (d_val),
            .live_o     (live_a[i]),
            .val_o      (val_a[i]),
            .flag_o     (flag_a[i]),
            .nxt_live_o (n_live),
            .nxt_val_o  (nxt_flat[i*DATA_W +: DATA_W])
         );

         assign live_vec[i]                  = live_a[i];
         assign val_flat[i*DATA_W +: DATA_W] = val_a[i];
      end
   endgenerate

   rwf_rank_pick #(.DATA_W(DATA_W), .DEPTH(DEPTH), .SEL_W(RANK_W)) u_pick (
      .vals_flat (nxt_flat),
      .sel       (rank_sel),
      .pick      (picked)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q     <= PH_IDLE;
         hold_q      <= '0;
         fill_q      <= '0;
         out_valid_q <= 1'b0;
         out_q       <= '0;
      end else begin
         out_valid_q <= 1'b0;
         if (accept) begin
            phase_q <= PH_INS;
            hold_q  <= in_sample;
         end else if (phase_q == PH_INS) begin
            phase_q <= PH_IDLE;
            if (!full) fill_q <= fill_q + 1'b1;
            if (full || (fill_q == CNT_W'(DEPTH - 1))) begin
               out_valid_q <= 1'b1;
               out_q       <= picked;
            end
         end
      end
   end

   assign out_valid  = out_valid_q;
   assign out_sample = out_q;
endmodule

// File: rtl/rwf_checker.sv
module rwf_checker #(
   parameter int DATA_W = 12,
   parameter int DEPTH  = 64
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_valid,
   input logic                     out_valid,
   input logic [DATA_W-1:0]        out_sample,
   input logic [DEPTH-1:0]         live_vec,
   input logic [DEPTH*DATA_W-1:0]  val_flat
);
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic             busy_c;
   logic             acc_c;
   logic [CNT_W-1:0] seen_c;

   assign acc_c = in_valid && !busy_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_c <= 1'b0;
         seen_c <= '0;
      end else begin
         busy_c <= acc_c;
         if (acc_c && (seen_c != CNT_W'(DEPTH))) seen_c <= seen_c + 1'b1;
      end
   end

   AST_NO_EARLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (seen_c == CNT_W'(DEPTH)));  // R5

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(acc_c, 2));  // R4

   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);  // R4

   AST_OUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(acc_c, 2) |-> $stable(out_sample));  // R8

   AST_FILL_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_c |-> ($countones(live_vec) == int'(seen_c)));  // R1

   generate
      for (genvar i = 0; i < DEPTH - 1; i++) begin : g_order
         AST_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
            live_vec[i+1] |-> (live_vec[i] &&
               (val_flat[i*DATA_W +: DATA_W] >= val_flat[(i+1)*DATA_W +: DATA_W])));  // R2
      end
   endgenerate
endmodule

bind rank_window_filter rwf_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_valid   (in_valid),
   .out_valid  (out_valid),
   .out_sample (out_sample),
   .live_vec   (live_vec),
   .val_flat   (val_flat)
);

// File: tb/rank_window_filter_tb.sv
`timescale 1ns/1ps
module rank_window_filter_tb;
   localparam int DW  = 4;
   localparam int DEP = 8;
   localparam int RW  = $clog2(DEP);
   localparam int MAXV = (1 << DW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] in_sample = '0;
   logic [RW-1:0] rank_sel = '0;
   logic          out_valid;
   logic [DW-1:0] out_sample;

   int n_chk = 0;
   int n_bad = 0;
   int hist [2048];
   int n_hist = 0;
   int last_out = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   rank_window_filter #(.DATA_W(DW), .DEPTH(DEP)) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_sample  (in_sample),
      .rank_sel   (rank_sel),
      .out_valid  (out_valid),
      .out_sample (out_sample)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   // (r+1)-th largest among the last DEP model samples
   function automatic int ranked(input int r);
      for (int j = n_hist - DEP; j < n_hist; j++) begin
         int gt = 0;
         int ge = 0;
         for (int m = n_hist - DEP; m < n_hist; m++) begin
            if (hist[m] > hist[j]) gt++;
            if (hist[m] >= hist[j]) ge++;
         end
         if (gt <= r && r < ge) return hist[j];
      end
      return -1;
   endfunction

   // One macrocycle; optional ignored pulse in the busy cycle
   task automatic send(input int x, input int r, input bit junk, input int jv, input string req);
      in_valid  = 1'b1;
      in_sample = DW'(x);
      rank_sel  = RW'(r);
      hist[n_hist] = x;
      n_hist++;
      @(negedge clk);
      chk(out_valid == 1'b0, "R4", int'(out_valid), 0);
      chk(int'(out_sample) == last_out, "R8", int'(out_sample), last_out);
      if (junk) begin
         in_valid  = 1'b1;
         in_sample = DW'(jv);
      end else begin
         in_valid = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b0;
      if (n_hist >= DEP) begin
         chk(out_valid == 1'b1, "R4", int'(out_valid), 1);
         chk(int'(out_sample) == ranked(r), req, int'(out_sample), ranked(r));
         last_out = int'(out_sample);
      end else begin
         chk(out_valid == 1'b0, "R5", int'(out_valid), 0);
      end
   endtask

   task automatic idle(input int k);
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         chk(out_valid == 1'b0, "R8", int'(out_valid), 0);
         chk(int'(out_sample) == last_out, "R8", int'(out_sample), last_out);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R9", int'(out_valid), 0);
      chk(out_sample == '0, "R9", int'(out_sample), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(out_valid == 1'b0 && out_sample == '0, "R9", int'(out_sample), 0);

      // Fill: no result until the window is full (R5), includes value 0 (R1)
      for (int i = 0; i < DEP; i++) send((i * 3) % (MAXV + 1), 0, 1'b0, 0, "R5");

      // Main sweep over every rank with ignored busy pulses (R1, R3)
      for (int i = 0; i < 320; i++) begin
         int v = (i * 7 + i / 16) % (MAXV + 1);
         if (i % 3 == 0)
            send(v, i % DEP, 1'b1, (i % 2 == 0) ? MAXV : 0, "R3");
         else
            send(v, i % DEP, 1'b0, 0, "R1");
         if (i % 41 == 0) idle(2);
      end

      // Equal values: one copy removed per expiry (R6)
      for (int i = 0; i < 96; i++) begin
         int v = ((i % 5) < 3) ? 5 : ((i % 7 == 0) ? 9 : 5);
         send(v, (i * 3) % DEP, 1'b0, 0, "R6");
      end

      // Expiry timing: DEP copies of the top value, then smaller ones (R7)
      for (int i = 0; i < DEP; i++) send(MAXV, 0, 1'b0, 0, "R7");
      for (int i = 0; i < DEP + 2; i++) send(i % 3, 0, 1'b0, 0, "R7");

      // Rank extremes: max, min, median (R2)
      for (int i = 0; i < 60; i++) begin
         int rk = (i % 3 == 0) ? 0 : ((i % 3 == 1) ? DEP - 1 : DEP / 2 - 1);
         send((i % 2 == 0) ? 0 : MAXV - (i % 4), rk, 1'b0, 0, "R2");
      end

      idle(4);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule